// File: doc/BRIEF.md
# Power-Fail Chip-Enable Gate with System Reset

This block sits between a processor's active-low memory chip-enable and two banks of battery-backed static memory. While power is good, it steers the incoming chip-enable to one of two bank enables according to a bank-select bit. The steering is combinational, so it adds no cycle of latency. When an external comparator raises a power-fail flag, the block write-protects both banks by holding both bank enables inactive. It also drives a system reset.

An access that is already under way when the flag is first sampled may finish on the bank it started on. This grace period is capped by a write-protect timeout. Once power is valid again, the block keeps both bank enables inactive and the reset asserted for a recovery interval. Only then does normal steering resume. The same recovery interval follows the block's own reset, so it doubles as a power-on reset generator. Both intervals are parameters counted in clock cycles.

Top module: `pfg_top`

## Requirements
- R1: While `rst` is high, and for `REC_CYCLES` clock edges after it falls, `sys_reset` is 1 and both bank enables are 1. On the next cycle normal steering applies.
- R2: In normal operation, `ce_n` = 1 drives `ce_out1_n` = 1 and `ce_out2_n` = 1 in the same cycle.
- R3: In normal operation with `ce_n` = 0, `bank_sel` = 0 drives `ce_out1_n` low and `bank_sel` = 1 drives `ce_out2_n` low. The other output stays 1. The change is combinational, within the same cycle.
- R4: In normal operation, if `pwr_fail` is sampled 1 at a clock edge while `ce_n` is 1, then from that edge both bank enables are 1 and `sys_reset` is 1.
- R5: In normal operation, if `pwr_fail` is sampled 1 while `ce_n` is 0, the access continues on the bank selected at that edge. Later changes of `bank_sel` have no effect, and `sys_reset` stays 0. The access ends at the first edge that samples `ce_n` = 1, which protects both banks and asserts `sys_reset`.
- R6: An access continued under R5 is cut off `WP_CYCLES` edges after the detecting edge, even if `ce_n` is still 0. Both enables go to 1 and `sys_reset` goes to 1.
- R7: Once write protection is in force, a `ce_n` low is never passed to either bank until recovery completes.
- R8: While protected, the first edge that samples `pwr_fail` = 0 starts recovery. Recovery lasts `REC_CYCLES` edges with both enables at 1 and `sys_reset` at 1, after which normal steering resumes.
- R9: If `pwr_fail` is sampled 1 during recovery, the block returns to protection. The next recovery then runs its full length again.
- R10: The two bank enables are never both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset; leads into recovery |
| pwr_fail | input | 1 | Power-fail flag from the supply comparator, active high |
| ce_n | input | 1 | Active-low chip-enable from the processor |
| bank_sel | input | 1 | Bank select: 0 for bank 1, 1 for bank 2 |
| ce_out1_n | output | 1 | Active-low chip-enable of bank 1 |
| ce_out2_n | output | 1 | Active-low chip-enable of bank 2 |
| sys_reset | output | 1 | System reset, active high |

## Verification
The bench builds the block with `WP_CYCLES` = 5 and `REC_CYCLES` = 8. With these values the timeout cutoff of a long access and the full recovery count both fall within a few dozen cycles. This makes it practical to drive an access that outlives the timeout and to re-raise the flag mid-recovery. Each recovery can then be followed to its release on the exact expected edge. The small values also let one run cover bank changes during a drained access and a fresh `ce_n` low after the access has ended.

// File: rtl/pfg_pkg.sv
package pfg_pkg;

    typedef enum logic [1:0] {
        PH_RUN     = 2'd0,
        PH_DRAIN   = 2'd1,
        PH_HOLD    = 2'd2,
        PH_RECOVER = 2'd3
    } phase_e;

    localparam int unsigned NBANK = 2;

endpackage

// File: rtl/pfg_bank_dec.sv
module pfg_bank_dec #(
    parameter int unsigned NB    = 2,
    localparam int unsigned SEL_W = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic             ce_n,
    input  logic             en,
    input  logic [SEL_W-1:0] sel,
    output logic [NB-1:0]    out_n
);

    // One comparator per bank; a bank is enabled only when passing is allowed.
    for (genvar i = 0; i < NB; i++) begin : g_bank
        always_comb begin
            out_n[i] = 1'b1;
            if (en && !ce_n && (sel == SEL_W'(i))) begin
                out_n[i] = 1'b0;
            end
        end
    end

endmodule

// File: rtl/pfg_seq.sv
module pfg_seq
    import pfg_pkg::*;
#(
    parameter int unsigned WP_CYCLES  = 37500,
    parameter int unsigned REC_CYCLES = 10000000,
    parameter int unsigned CNT_W      = 24
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   pwr_fail,
    input  logic   ce_n,
    input  logic   bank_sel,
    output phase_e phase,
    output logic   drain_bank
);

    localparam logic [CNT_W-1:0] WP_LAST  = CNT_W'(WP_CYCLES - 1);
    localparam logic [CNT_W-1:0] REC_LAST = CNT_W'(REC_CYCLES - 1);

    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] cnt;
        logic             bank;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.ph)
            PH_RUN: begin
                if (pwr_fail) begin
                    st_d.cnt = '0;
                    if (!ce_n) begin
                        st_d.ph   = PH_DRAIN;
                        st_d.bank = bank_sel;
                    end else begin
                        st_d.ph = PH_HOLD;
                    end
                end
            end
            PH_DRAIN: begin
                if (ce_n || (st_q.cnt == WP_LAST)) begin
                    st_d.ph  = PH_HOLD;
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            PH_HOLD: begin
                if (!pwr_fail) begin
                    st_d.ph  = PH_RECOVER;
                    st_d.cnt = '0;
                end
            end
            PH_RECOVER: begin
                if (pwr_fail) begin
                    st_d.ph  = PH_HOLD;
                    st_d.cnt = '0;
                end else if (st_q.cnt == REC_LAST) begin
                    st_d.ph  = PH_RUN;
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            default: st_d.ph = PH_HOLD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.ph   <= PH_RECOVER;
            st_q.cnt  <= '0;
            st_q.bank <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase      = st_q.ph;
    assign drain_bank = st_q.bank;

endmodule

// File: rtl/pfg_top.sv
module pfg_top
    import pfg_pkg::*;
#(
    parameter int unsigned WP_CYCLES  = 37500,
    parameter int unsigned REC_CYCLES = 10000000,
    localparam int unsigned CNT_MAX   = (WP_CYCLES > REC_CYCLES) ? WP_CYCLES : REC_CYCLES,
    localparam int unsigned CNT_W     = $clog2(CNT_MAX + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic pwr_fail,
    input  logic ce_n,
    input  logic bank_sel,
    output logic ce_out1_n,
    output logic ce_out2_n,
    output logic sys_reset
);

    phase_e           phase;
    logic             drain_bank;
    logic             pass_en;
    logic             eff_sel;
    logic [NBANK-1:0] bank_n;

    pfg_seq #(
        .WP_CYCLES (WP_CYCLES),
        .REC_CYCLES(REC_CYCLES),
        .CNT_W     (CNT_W)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .pwr_fail  (pwr_fail),
        .ce_n      (ce_n),
        .bank_sel  (bank_sel),
        .phase     (phase),
        .drain_bank(drain_bank)
    );

    // The bank is frozen while an interrupted access drains.
    always_comb begin
        pass_en = (phase == PH_RUN) || (phase == PH_DRAIN);
        eff_sel = (phase == PH_DRAIN) ? drain_bank : bank_sel;
    end

    pfg_bank_dec #(.NB(NBANK)) u_dec (
        .ce_n (ce_n),
        .en   (pass_en),
        .sel  (eff_sel),
        .out_n(bank_n)
    );

    assign ce_out1_n = bank_n[0];
    assign ce_out2_n = bank_n[1];
    assign sys_reset = (phase == PH_HOLD) || (phase == PH_RECOVER);

endmodule

// File: rtl/pfg_chk.sv
module pfg_chk (
    input logic clk,
    input logic rst,
    input logic pwr_fail,
    input logic ce_n,
    input logic ce_out1_n,
    input logic ce_out2_n,
    input logic sys_reset
);

    AST_ONE_BANK: assert property (@(posedge clk) disable iff (rst)
        (ce_out1_n || ce_out2_n)); // R10

    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
        ce_n |-> (ce_out1_n && ce_out2_n)); // R2

    AST_RESET_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        sys_reset |-> (ce_out1_n && ce_out2_n)); // R8

    AST_FAIL_PROTECT: assert property (@(posedge clk) disable iff (rst)
        (pwr_fail && ce_n) |=> sys_reset); // R4

    AST_HOLD_STICKY: assert property (@(posedge clk) disable iff (rst)
        (sys_reset && pwr_fail) |=> sys_reset); // R9

endmodule

bind pfg_top pfg_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .pwr_fail (pwr_fail),
    .ce_n     (ce_n),
    .ce_out1_n(ce_out1_n),
    .ce_out2_n(ce_out2_n),
    .sys_reset(sys_reset)
);

// File: tb/sim_pfg_top.sv
`timescale 1ns/1ps
module sim_pfg_top;

    localparam int WP  = 5;
    localparam int REC = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pwr_fail = 1'b0;
    logic ce_n = 1'b1;
    logic bank_sel = 1'b0;
    logic ce_out1_n, ce_out2_n, sys_reset;

    always #2 clk = ~clk;

    pfg_top #(.WP_CYCLES(WP), .REC_CYCLES(REC)) u0 (
        .clk(clk), .rst(rst), .pwr_fail(pwr_fail), .ce_n(ce_n),
        .bank_sel(bank_sel), .ce_out1_n(ce_out1_n),
        .ce_out2_n(ce_out2_n), .sys_reset(sys_reset)
    );

    int n_chk  = 0;
    int n_fail = 0;
    string tag = "R1";

    // Behavioural model: 0 normal, 1 finishing access, 2 protected, 3 recovering
    int mode = 3;
    int elapsed = 0;
    int left = REC;
    logic held_bank = 1'b0;

    task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {ce1,ce2,rst}=%b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(input logic r, input logic pf, input logic ce, input logic bs);
        logic e1, e2, er;
        rst = r; pwr_fail = pf; ce_n = ce; bank_sel = bs;
        #1;
        e1 = 1'b1; e2 = 1'b1;
        if (mode == 0 && !ce) begin e1 = bs; e2 = !bs; end
        if (mode == 1 && !ce) begin e1 = held_bank; e2 = !held_bank; end
        er = (mode >= 2);
        if (!r) check(tag, {ce_out1_n, ce_out2_n, sys_reset}, {e1, e2, er});
        else check("R1", {ce_out1_n, ce_out2_n}, 2'b11);
        n_chk++;
        if (!ce_out1_n && !ce_out2_n) begin
            n_fail++;
            $display("FAIL R10: both enables low, expected at most one at %0t", $time);
        end
        @(posedge clk);
        if (r) begin
            mode = 3; left = REC;
        end else begin
            case (mode)
                0: if (pf) begin
                       if (!ce) begin mode = 1; elapsed = 0; held_bank = bs; end
                       else mode = 2;
                   end
                1: begin
                       elapsed++;
                       if (ce || elapsed == WP) mode = 2;
                   end
                2: if (!pf) begin mode = 3; left = REC; end
                default: begin
                       if (pf) mode = 2;
                       else begin
                           left--;
                           if (left == 0) mode = 0;
                       end
                   end
            endcase
        end
        @(negedge clk);
    endtask

    task automatic recover(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 1'b1, 1'b0);
    endtask

    initial begin
        #(200000 * 4);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        @(negedge clk);
        tag = "R1";
        cyc(1, 0, 1, 0); cyc(1, 0, 0, 0); cyc(1, 0, 0, 1);
        for (int i = 0; i < REC + 2; i++) cyc(0, 0, (i % 2 == 0), i[1]);
        tag = "R2";
        cyc(0, 0, 1, 0); cyc(0, 0, 1, 1); cyc(0, 0, 1, 0);
        tag = "R3";
        cyc(0, 0, 0, 0); cyc(0, 0, 0, 1); cyc(0, 0, 0, 0); cyc(0, 0, 1, 1); cyc(0, 0, 0, 1);
        tag = "R4";
        cyc(0, 1, 1, 0); cyc(0, 1, 0, 0); cyc(0, 1, 0, 1);
        tag = "R8";
        recover(REC + 2);
        tag = "R5";
        cyc(0, 0, 0, 0); cyc(0, 1, 0, 0); cyc(0, 1, 0, 1); cyc(0, 0, 0, 1);
        cyc(0, 1, 1, 1); cyc(0, 1, 0, 0);
        tag = "R8";
        recover(REC + 2);
        tag = "R6";
        cyc(0, 1, 0, 1);
        for (int i = 0; i < WP + 3; i++) cyc(0, 1, 0, (i % 2 == 0));
        recover(REC + 2);
        tag = "R7";
        cyc(0, 1, 0, 0); cyc(0, 1, 1, 0); cyc(0, 1, 0, 0); cyc(0, 0, 0, 1); cyc(0, 0, 0, 0);
        recover(REC + 2);
        tag = "R9";
        cyc(0, 1, 1, 0); cyc(0, 0, 1, 0); cyc(0, 0, 1, 0); cyc(0, 0, 1, 0);
        cyc(0, 1, 0, 0); cyc(0, 1, 0, 1);
        for (int i = 0; i < REC + 2; i++) cyc(0, 0, 0, i[0]);
        tag = "R3";
        cyc(0, 0, 0, 1); cyc(0, 0, 0, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule